// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers twenty level-sensitive interrupt requests (eight from two serial channels, eight from four DMA channels and four from timers) into a single interrupt line toward a host processor. Each request can be masked by its own enable bit. The highest-priority request that is both pending and enabled is chosen by a fixed order. A control bit decides whether the serial group or the DMA group ranks first. The timer group always ranks last.

When the host acknowledges, the block captures the winning source as a six-bit code. It then presents an eight-bit vector. In fixed mode the vector is the programmed vector byte unchanged. In modified mode the vector keeps the two upper bits of the programmed byte and puts the captured source code in its low six bits. The captured code holds until the next acknowledge, so the host can read a stable vector. A byte-wide register port gives access to the enables, the control bits and the vector byte. It also shows the raw request levels as read-only status.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, all enables, the control bits and the vector byte are 0, `irqOut` is 0 and `vecOut` is 0x00.
- R2: The status addresses 2 (serial, bit k = request k), 3 (DMA, bit k = request 8+k) and 4 (timer, bits 3:0 = requests 16..19) read back the live `reqIn` levels whatever the enables are. A write to any of these addresses changes no register.
- R3: `irqOut` is 1 exactly when at least one request is both high and enabled. A request whose enable bit is 0 never raises `irqOut` and never wins.
- R4: With control bit 0 (group swap) at 0, serial outranks DMA, which outranks timers. Serial request k gets code k, DMA request k gets code 8+k, and timer request k gets code 16+k.
- R5: With group swap at 1, DMA outranks serial, which outranks timers. DMA request k gets code k, serial request k gets code 8+k, and timer request k still gets code 16+k.
- R6: Within a group, the lower-numbered request has the higher priority. Serial requests are numbered in the order channel-0 RX ready, TX ready, RX event, TX event, then the same four for channel 1. DMA requests are numbered channel 0 A, B, then channel 1 A, B, and so on.
- R7: With control bit 1 (modified vector) at 0, `vecOut` equals the vector byte at address 1.
- R8: With modified vector at 1, `vecOut` equals {vector byte bits 7:6, captured code}.
- R9: The code is captured on the clock edge where `ackStrobe` is high, from the request and enable state before that edge. It then stays unchanged until the next acknowledge, even if requests or enables change.
- R10: An acknowledge that finds no enabled pending request captures code 63.
- R11: The register port reads back control at address 0 (bits 1:0, upper bits 0), the vector byte at address 1, and the enables at addresses 5 (serial), 6 (DMA) and 7 (timer, bits 3:0, upper bits 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | 20 | Request levels: bits 7:0 serial, 15:8 DMA, 19:16 timer |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| ackStrobe | input | 1 | Acknowledge; captures the winning code |
| irqOut | output | 1 | Interrupt request to the host |
| vecOut | output | 8 | Vector presented to the host |

## Verification
An acknowledge and a register write can land on the same clock edge. The interesting case is a write that enables a higher-ranked request in the very cycle that captures the winner. The bench provokes this by raising `ackStrobe` together with an enable write. It expects the captured code to name the source that won under the old enables, while `irqOut` and the next acknowledge reflect the new ones. It also checks that request changes after an acknowledge leave the presented vector unchanged.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int CODE_W = 6;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_VEC    = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_ST_SER = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_ST_DMA = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_ST_TMR = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_EN_SER = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_EN_DMA = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_EN_TMR = 3'd7;

  typedef struct packed {
    logic wrCtrl;
    logic wrVec;
    logic wrEnSer;
    logic wrEnDma;
    logic wrEnTmr;
    logic ackLatch;
  } strobe_t;
endpackage

// File: rtl/ivc_ctrl.sv
module ivc_ctrl
  import ivc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              ackStrobe,
  output strobe_t           strobes
);
  always_comb begin
    strobes          = '0;
    strobes.ackLatch = ackStrobe;
    if (regWrEn) begin
      unique case (regAddr)
        ADR_CTRL:   strobes.wrCtrl  = 1'b1;
        ADR_VEC:    strobes.wrVec   = 1'b1;
        ADR_EN_SER: strobes.wrEnSer = 1'b1;
        ADR_EN_DMA: strobes.wrEnDma = 1'b1;
        ADR_EN_TMR: strobes.wrEnTmr = 1'b1;
        default: ;
      endcase
    end
  end

  // R2: at most one register write strobe per cycle; status addresses raise none
  a_r2_one_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrCtrl, strobes.wrVec, strobes.wrEnSer, strobes.wrEnDma, strobes.wrEnTmr}));
  a_r2_status_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regAddr == ADR_ST_SER || regAddr == ADR_ST_DMA || regAddr == ADR_ST_TMR))
      |-> !(strobes.wrCtrl || strobes.wrVec || strobes.wrEnSer || strobes.wrEnDma || strobes.wrEnTmr));
endmodule

// File: rtl/ivc_datapath.sv
module ivc_datapath
  import ivc_pkg::*;
#(
  parameter int NUM_SER = 8,
  parameter int NUM_DMA = 8,
  parameter int NUM_TMR = 4,
  localparam int NUM_SRC = NUM_SER + NUM_DMA + NUM_TMR
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [NUM_SRC-1:0] reqIn,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut,
  output logic [DATA_W-1:0] vecOut
);
  localparam int SER_LO = 0;
  localparam int DMA_LO = NUM_SER;
  localparam int TMR_LO = NUM_SER + NUM_DMA;
  localparam logic [CODE_W-1:0] IDLE_CODE = '1;

  logic [NUM_SER-1:0] enSer;
  logic [NUM_DMA-1:0] enDma;
  logic [NUM_TMR-1:0] enTmr;
  logic               groupSwap;
  logic               modVec;
  logic [DATA_W-1:0]  vecBase;
  logic [CODE_W-1:0]  codeQ;

  logic [NUM_SER-1:0] reqSer, actSer;
  logic [NUM_DMA-1:0] reqDma, actDma;
  logic [NUM_TMR-1:0] reqTmr, actTmr;
  logic [NUM_SRC-1:0] ordered;
  logic [CODE_W-1:0]  winCode;
  logic               anyPending;

  assign reqSer = reqIn[SER_LO +: NUM_SER];
  assign reqDma = reqIn[DMA_LO +: NUM_DMA];
  assign reqTmr = reqIn[TMR_LO +: NUM_TMR];

  // masking, one gate per source
  for (genvar s = 0; s < NUM_SER; s++) begin : g_ser
    assign actSer[s] = reqSer[s] & enSer[s];
  end
  for (genvar d = 0; d < NUM_DMA; d++) begin : g_dma
    assign actDma[d] = reqDma[d] & enDma[d];
  end
  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    assign actTmr[t] = reqTmr[t] & enTmr[t];
  end

  // bit 0 of ordered is the top-ranked source
  always_comb begin
    if (groupSwap) ordered = {actTmr, actSer, actDma};
    else           ordered = {actTmr, actDma, actSer};
  end

  always_comb begin
    winCode = IDLE_CODE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (ordered[i]) winCode = CODE_W'(i);
    end
  end

  assign anyPending = |ordered;
  assign irqOut     = |{actTmr, actDma, actSer};

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enSer     <= '0;
      enDma     <= '0;
      enTmr     <= '0;
      groupSwap <= 1'b0;
      modVec    <= 1'b0;
      vecBase   <= '0;
    end else begin
      if (strobes.wrCtrl) begin
        groupSwap <= regWrData[0];
        modVec    <= regWrData[1];
      end
      if (strobes.wrVec)   vecBase <= regWrData;
      if (strobes.wrEnSer) enSer   <= regWrData[NUM_SER-1:0];
      if (strobes.wrEnDma) enDma   <= regWrData[NUM_DMA-1:0];
      if (strobes.wrEnTmr) enTmr   <= regWrData[NUM_TMR-1:0];
    end
  end

  // code capture at acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 codeQ <= IDLE_CODE;
    else if (strobes.ackLatch) codeQ <= winCode;
  end

  always_comb begin
    if (modVec) vecOut = {vecBase[DATA_W-1:CODE_W], codeQ};
    else        vecOut = vecBase;
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADR_CTRL:   regRdData = {{(DATA_W-2){1'b0}}, modVec, groupSwap};
      ADR_VEC:    regRdData = vecBase;
      ADR_ST_SER: regRdData = DATA_W'(reqSer);
      ADR_ST_DMA: regRdData = DATA_W'(reqDma);
      ADR_ST_TMR: regRdData = DATA_W'(reqTmr);
      ADR_EN_SER: regRdData = DATA_W'(enSer);
      ADR_EN_DMA: regRdData = DATA_W'(enDma);
      ADR_EN_TMR: regRdData = DATA_W'(enTmr);
      default: ;
    endcase
  end

  // R3: with every enable clear the request line stays low
  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (enSer == '0 && enDma == '0 && enTmr == '0) |-> !irqOut);
  // R9: the captured code moves only on an acknowledge
  a_r9_code_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.ackLatch |=> $stable(codeQ));
  // R10: an empty acknowledge leaves the idle code
  a_r10_idle_code: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ackLatch && !irqOut) |=> (codeQ == IDLE_CODE));
  // R4: a real winner always carries an in-range code
  a_r4_code_range: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ackLatch && irqOut) |=> (int'(codeQ) < NUM_SRC));
  // R8: modified vector keeps the programmed top bits
  a_r8_top_bits: assert property (@(posedge clk) disable iff (!rstN)
    modVec |-> (vecOut[DATA_W-1:CODE_W] == vecBase[DATA_W-1:CODE_W]));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_SER = 8,
  parameter int NUM_DMA = 8,
  parameter int NUM_TMR = 4,
  localparam int NUM_SRC = NUM_SER + NUM_DMA + NUM_TMR
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               ackStrobe,
  output logic               irqOut,
  output logic [DATA_W-1:0]  vecOut
);
  strobe_t strobes;

  ivc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .ackStrobe (ackStrobe),
    .strobes   (strobes)
  );

  ivc_datapath #(
    .NUM_SER (NUM_SER),
    .NUM_DMA (NUM_DMA),
    .NUM_TMR (NUM_TMR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .reqIn     (reqIn),
    .regRdData (regRdData),
    .irqOut    (irqOut),
    .vecOut    (vecOut)
  );
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] reqIn = '0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        ackStrobe = 1'b0;
  logic        irqOut;
  logic [7:0]  vecOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .ackStrobe(ackStrobe),
    .irqOut(irqOut), .vecOut(vecOut)
  );

  localparam logic [7:0] BASE = 8'hC0;

  // {swap, mod, req[19:0], en[19:0], expCode[5:0], expIrq}
  typedef struct packed {
    logic        swap;
    logic        modv;
    logic [19:0] req;
    logic [19:0] en;
    logic [5:0]  code;
    logic        irq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TABLE [NV] = '{
    '{1'b0, 1'b1, 20'h00001, 20'hFFFFF, 6'd0,  1'b1},  // R4 top serial
    '{1'b0, 1'b1, 20'h00208, 20'hFFFFF, 6'd3,  1'b1},  // R4 serial over DMA
    '{1'b0, 1'b1, 20'h20200, 20'hFFFFF, 6'd9,  1'b1},  // R4 DMA over timer
    '{1'b1, 1'b1, 20'h00208, 20'hFFFFF, 6'd1,  1'b1},  // R5 DMA over serial
    '{1'b1, 1'b1, 20'h20008, 20'hFFFFF, 6'd11, 1'b1},  // R5 serial code offset
    '{1'b0, 1'b1, 20'h80000, 20'hFFFFF, 6'd19, 1'b1},  // R4 last timer
    '{1'b1, 1'b1, 20'h10000, 20'hFFFFF, 6'd16, 1'b1},  // R5 timer code fixed
    '{1'b0, 1'b1, 20'h00021, 20'hFFFFE, 6'd5,  1'b1},  // R3 masked top source
    '{1'b0, 1'b0, 20'h00004, 20'hFFFFF, 6'd2,  1'b1},  // R7 fixed vector
    '{1'b0, 1'b1, 20'h00010, 20'h00000, 6'd63, 1'b0},  // R10 nothing enabled
    '{1'b1, 1'b1, 20'hFFFFF, 20'hFFFFF, 6'd0,  1'b1},  // R6 all pending, swap
    '{1'b0, 1'b1, 20'hFFFFF, 20'hF0000, 6'd16, 1'b1}   // R6 only timers enabled
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic ack();
    @(negedge clk);
    ackStrobe = 1'b1;
    @(negedge clk);
    ackStrobe = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] expVec;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", irqOut, 0);
    check("R1 vec", vecOut, 8'h00);
    rd(3'd0, r); check("R1 ctrl", r, 0);
    rd(3'd5, r); check("R1 enSer", r, 0);

    // R2 status mirror and read-only
    reqIn = 20'hA5_3C_5;
    rd(3'd2, r); check("R2 serial status", r, 8'hC5);
    rd(3'd3, r); check("R2 dma status", r, 8'hA5 >> 0 & 8'hFF ^ 8'h00 ? 8'h53 : 8'h53);
    rd(3'd4, r); check("R2 timer status", r, 8'h0A);
    reqIn = '0;
    wr(3'd2, 8'hFF);
    wr(3'd4, 8'hFF);
    rd(3'd2, r); check("R2 status write ignored", r, 0);
    rd(3'd5, r); check("R2 enSer untouched", r, 0);
    rd(3'd7, r); check("R2 enTmr untouched", r, 0);
    check("R2 irq quiet", irqOut, 0);

    // R11 readback
    wr(3'd0, 8'hFF); rd(3'd0, r); check("R11 ctrl bits", r, 8'h03);
    wr(3'd7, 8'hFF); rd(3'd7, r); check("R11 timer enable width", r, 8'h0F);
    wr(3'd1, BASE);  rd(3'd1, r); check("R11 vector byte", r, BASE);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, {6'd0, TABLE[i].modv, TABLE[i].swap});
      wr(3'd5, TABLE[i].en[7:0]);
      wr(3'd6, TABLE[i].en[15:8]);
      wr(3'd7, {4'd0, TABLE[i].en[19:16]});
      @(negedge clk);
      reqIn = TABLE[i].req;
      #1 check($sformatf("R3 irq row %0d", i), irqOut, TABLE[i].irq);
      ack();
      expVec = TABLE[i].modv ? {BASE[7:6], TABLE[i].code} : BASE;
      check($sformatf("R4/R5/R8 vector row %0d", i), vecOut, expVec);
    end

    // R7 fixed mode: switch back after a capture; vector is the plain byte
    wr(3'd0, 8'h00);
    @(negedge clk);
    check("R7 fixed vector", vecOut, BASE);

    // R9 hold after capture while requests change
    wr(3'd0, 8'h02);
    wr(3'd5, 8'hFF);
    reqIn = 20'h00040;
    ack();
    check("R9 captured", vecOut, {BASE[7:6], 6'd6});
    reqIn = 20'h00001;
    repeat (3) @(negedge clk);
    check("R9 held after request change", vecOut, {BASE[7:6], 6'd6});

    // R9 acknowledge coinciding with an enable write
    wr(3'd5, 8'h02);
    reqIn = 20'h00003;
    @(negedge clk);
    regAddr = 3'd5; regWrData = 8'hFF; regWrEn = 1'b1; ackStrobe = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; ackStrobe = 1'b0;
    check("R9 same-cycle uses old enables", vecOut, {BASE[7:6], 6'd1});
    check("R3 irq with new enables", irqOut, 1);
    ack();
    check("R9 next ack uses new enables", vecOut, {BASE[7:6], 6'd0});

    // R10 empty acknowledge after a valid one
    reqIn = '0;
    ack();
    check("R10 idle code", vecOut, {BASE[7:6], 6'd63});

    // R1 reset again clears configuration
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R1 vec after reset", vecOut, 0);
    rd(3'd1, r); check("R1 vector byte after reset", r, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule